// File: doc/BRIEF.md
# Key-Guarded Escalating Watchdog Timer

This block is a memory-mapped watchdog. A down-counter runs while the control enable bit is set. When the counter reaches zero, the raw interrupt flag is set and the counter starts again from the load value. If software has not cleared the flag by the time the next timeout arrives, and the reset enable bit is set, the block drives a reset request. That request stays high until the block itself is reset.

Software services the watchdog by rewriting the load value or by writing the interrupt clear register. Either action restarts the count. The load, control and clear registers accept writes only after one 32-bit key has been written to the lock register. Any other value written there closes the gate again. The block comes out of reset locked.

Registers are reached over a plain single-cycle register port: a write strobe, a word address, write data, and read data that follows the address combinationally. The port has no handshake, no wait states and no back-pressure, because every access completes in the cycle it is presented. Identification bytes are read-only and are set by a parameter.

Top module: `guarded_wdt`

## Requirements
- R1: After reset the lock register (offset 0xC00) reads 1, the load (0x000), value (0x004), control (0x008) and raw status (0x010) registers read 0, and both `irq_o` and `rst_req_o` are low.
- R2: Writing 0x1ACCE551 to 0xC00 opens the write gate, and 0xC00 then reads 0. Writing any other value closes it, and 0xC00 then reads 1. The lock register accepts writes in either state.
- R3: While the gate is closed, writes to 0x000, 0x008 and 0x00C change nothing.
- R4: An open write to 0x000 stores the load value and sets the counter to it at the same edge. Offset 0x004 reads the current count. The count falls by one per cycle while control bit 0 is set.
- R5: At a clock edge where control bit 0 is set and the count is zero, raw status bit 0 (0x010) is set and the counter reloads. A load of L therefore times out L+1 edges after the counter was loaded.
- R6: Masked status bit 0 (0x014) and `irq_o` equal raw status ANDed with control bit 0.
- R7: An open write of any value to 0x00C clears the raw status and reloads the counter from the load value.
- R8: A timeout that occurs while raw status is already set and control bit 1 is set raises `rst_req_o` at that edge. The output then stays high until `rst_n` is asserted. With control bit 1 clear, repeated timeouts never raise it.
- R9: Writing 0 to control freezes the count and drops `irq_o`. It does not lower a `rst_req_o` that is already high.
- R10: With a load value of 0 and the counter enabled, the raw status is set at the very next edge.
- R11: An open write to 0x00C or 0x000 in the same cycle as a timeout takes precedence. That edge sets no raw status and raises no reset, and the counter takes the reloaded value.
- R12: Offsets 0xFE0 + 4k, for k = 0..7, read byte k of the `ID_BYTES` parameter in bits 7:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Masked timeout interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
Two events can fall in the same cycle: a software service (a clear write or a load write) and the counter expiring. The bench provokes this by setting the raw flag with reset enabled and then landing a clear write on the exact edge where the count is zero. At that edge a second timeout would otherwise raise the reset. The outcome is judged at the ports: the reset request must stay low, raw status must read 0, and the value register must read the full load value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;
  // identification window: top 7 address bits all ones (0xFE0..0xFFC)
  localparam logic [6:0]        ID_WIN    = 7'h7F;

  localparam logic [DATA_W-1:0] GATE_KEY  = 32'h1ACC_E551;

  localparam int CTRL_W    = 2;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_RSTE = 1;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              unlocked,
  output logic              load_we,
  output logic              clr_we,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic open_wr;

  assign open_wr = bus_we && unlocked;
  assign load_we = open_wr && (bus_addr == OFS_LOAD);
  assign clr_we  = open_wr && (bus_addr == OFS_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (bus_we && (bus_addr == OFS_LOCK)) begin
      unlocked <= (bus_wdata == GATE_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (open_wr && (bus_addr == OFS_CTRL)) begin
      ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rst_en,
  input  logic             load_we,
  input  logic             clr_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] load_q,
  output logic             raw_q,
  output logic             rst_req_q
);
  logic expire;

  assign expire = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (load_we) begin
      load_q <= wdata;
    end
  end

  // software service beats a timeout in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else if (clr_we) begin
      cnt_q <= load_q;
      raw_q <= 1'b0;
    end else if (load_we) begin
      cnt_q <= wdata;
    end else if (expire) begin
      cnt_q <= load_q;
      raw_q <= 1'b1;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
    end else if (expire && raw_q && rst_en && !clr_we && !load_we) begin
      rst_req_q <= 1'b1;
    end
  end
endmodule

// File: rtl/guarded_wdt.sv
module guarded_wdt
  import wdt_pkg::*;
#(
  parameter logic [63:0] ID_BYTES = 64'hB1_05_F0_0D_04_18_29_A7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int ID_N  = 8;
  localparam int IDX_W = $clog2(ID_N);

  logic              unlocked;
  logic              load_we;
  logic              clr_we;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] load_q;
  logic              raw_q;
  logic [7:0]        id_byte [ID_N];
  logic [IDX_W-1:0]  id_idx;

  wdt_regif u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .unlocked  (unlocked),
    .load_we   (load_we),
    .clr_we    (clr_we),
    .ctrl_q    (ctrl_q)
  );

  wdt_counter #(.CNT_W(DATA_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q[CTRL_RUN]),
    .rst_en    (ctrl_q[CTRL_RSTE]),
    .load_we   (load_we),
    .clr_we    (clr_we),
    .wdata     (bus_wdata),
    .cnt_q     (cnt_q),
    .load_q    (load_q),
    .raw_q     (raw_q),
    .rst_req_q (rst_req_o)
  );

  assign irq_o = raw_q && ctrl_q[CTRL_RUN];

  for (genvar k = 0; k < ID_N; k++) begin : g_id
    assign id_byte[k] = ID_BYTES[8*k +: 8];
  end

  assign id_idx = bus_addr[IDX_W+1:2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[ADDR_W-1:IDX_W+2] == ID_WIN) begin
      bus_rdata[7:0] = id_byte[id_idx];
    end else begin
      case (bus_addr)
        OFS_LOAD:  bus_rdata = load_q;
        OFS_VALUE: bus_rdata = cnt_q;
        OFS_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
        OFS_RAW:   bus_rdata[0] = raw_q;
        OFS_MASK:  bus_rdata[0] = irq_o;
        OFS_LOCK:  bus_rdata[0] = !unlocked;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/guarded_wdt_chk.sv
module guarded_wdt_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rst_req_o,
  input logic              unlocked,
  input logic              load_we,
  input logic              clr_we,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] load_q,
  input logic              raw_q
);
  // R8
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> rst_req_o);

  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> ($past(raw_q) && $past(ctrl_q[CTRL_RSTE])));

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_LOCK && bus_wdata == GATE_KEY) |=> unlocked);

  // R3
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_we && bus_addr == OFS_CTRL) |=> $stable(ctrl_q));

  // R7
  clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (!raw_q && cnt_q == $past(load_q)));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTRL_RUN] && !load_we && !clr_we) |=> $stable(cnt_q));
endmodule

bind guarded_wdt guarded_wdt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rst_req_o (rst_req_o),
  .unlocked  (unlocked),
  .load_we   (load_we),
  .clr_we    (clr_we),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q),
  .load_q    (load_q),
  .raw_q     (raw_q)
);

// File: tb/guarded_wdt_tb.sv
module guarded_wdt_tb;
  localparam logic [63:0] IDB = 64'hB1_05_F0_0D_04_18_29_A7;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  guarded_wdt #(.ID_BYTES(IDB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .rst_req_o(rst_req_o)
  );

  // row: {is_write, addr, data-or-expected}
  localparam int NV = 14;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 12'hC00, 32'h1},          // R1 locked
    {1'b1, 12'h000, 32'h50},         // R3 locked load write
    {1'b0, 12'h000, 32'h0},          // R3 load unchanged
    {1'b1, 12'hC00, KEY},            // R2 open
    {1'b0, 12'hC00, 32'h0},          // R2 reads open
    {1'b1, 12'h000, 32'h40},
    {1'b0, 12'h000, 32'h40},         // R4 load stored
    {1'b1, 12'h008, 32'h3},
    {1'b0, 12'h008, 32'h3},
    {1'b1, 12'hC00, 32'h1},          // R2 close
    {1'b0, 12'hC00, 32'h1},
    {1'b1, 12'h008, 32'h0},          // R3 locked ctrl write
    {1'b0, 12'h008, 32'h3},          // R3 ctrl unchanged
    {1'b0, 12'h010, 32'h0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 rst_req", {31'b0, rst_req_o}, 32'h0);
    rd(12'h004, v); check("R1 value", v, 32'h0);
    rd(12'h008, v); check("R1 ctrl", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) begin
        wr(VEC[i][43:32], VEC[i][31:0]);
      end else begin
        rd(VEC[i][43:32], v);
        checks++;
        if (v !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R1/R2/R3 table row %0d: actual %h expected %h", i, v, VEC[i][31:0]);
        end
      end
    end

    // R12 identification bytes
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4*k), v);
      check("R12 id", v, {24'b0, IDB[8*k +: 8]});
    end

    // R4 R5 R6 timeout timing
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 32'd10);
    wr(12'h008, 32'h1);
    rd(12'h004, v); check("R4 value after load", v, 32'd10);
    repeat (3) @(negedge clk);
    rd(12'h004, v); check("R4 decrement", v, 32'd7);
    repeat (7) @(negedge clk);
    rd(12'h010, v); check("R5 raw before timeout", v, 32'h0);
    @(negedge clk);
    rd(12'h010, v); check("R5 raw at timeout", v, 32'h1);
    rd(12'h004, v); check("R5 reload", v, 32'd10);
    rd(12'h014, v); check("R6 masked", v, 32'h1);
    check("R6 irq", {31'b0, irq_o}, 32'h1);
    // R3 clear while locked
    wr(12'hC00, 32'h0);
    wr(12'h00C, 32'h1);
    rd(12'h010, v); check("R3 locked clear ignored", v, 32'h1);
    wr(12'hC00, KEY);
    wr(12'h00C, 32'h0);
    rd(12'h010, v); check("R7 raw cleared", v, 32'h0);
    rd(12'h004, v); check("R7 counter reloaded", v, 32'd10);
    check("R6 irq low", {31'b0, irq_o}, 32'h0);
    // R8 escalation
    wr(12'h008, 32'h3);
    repeat (10) @(negedge clk);
    rd(12'h010, v); check("R8 first timeout raw", v, 32'h1);
    check("R8 no reset on first timeout", {31'b0, rst_req_o}, 32'h0);
    repeat (10) @(negedge clk);
    check("R8 reset not early", {31'b0, rst_req_o}, 32'h0);
    @(negedge clk);
    check("R8 reset at second timeout", {31'b0, rst_req_o}, 32'h1);
    // R9 stop
    wr(12'h008, 32'h0);
    check("R9 irq dropped", {31'b0, irq_o}, 32'h0);
    rd(12'h014, v); check("R9 masked zero", v, 32'h0);
    rd(12'h004, v);
    repeat (4) @(negedge clk);
    begin
      logic [31:0] v2;
      rd(12'h004, v2); check("R9 count frozen", v2, v);
    end
    wr(12'h00C, 32'h1);
    check("R9 reset held", {31'b0, rst_req_o}, 32'h1);
    rd(12'h010, v); check("R6 raw reads zero after clear", v, 32'h0);

    // R8 no reset when bit1 clear
    do_reset();
    check("R8 reset released by rst_n", {31'b0, rst_req_o}, 32'h0);
    wr(12'hC00, KEY);
    wr(12'h000, 32'd2);
    wr(12'h008, 32'h1);
    repeat (12) @(negedge clk);
    check("R8 no reset without enable", {31'b0, rst_req_o}, 32'h0);

    // R10 zero load
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 32'd5);
    wr(12'h008, 32'h1);
    wr(12'h000, 32'd0);
    rd(12'h010, v); check("R10 raw before edge", v, 32'h0);
    @(negedge clk);
    rd(12'h010, v); check("R10 raw next clock", v, 32'h1);

    // R11 service coincides with expiry
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 32'd4);
    wr(12'h008, 32'h3);
    repeat (5) @(negedge clk);
    rd(12'h010, v); check("R11 setup raw", v, 32'h1);
    repeat (4) @(negedge clk);
    rd(12'h004, v); check("R11 count at zero", v, 32'h0);
    wr(12'h00C, 32'h1);
    check("R11 no reset", {31'b0, rst_req_o}, 32'h0);
    rd(12'h010, v); check("R11 raw cleared", v, 32'h0);
    rd(12'h004, v); check("R11 reload wins", v, 32'd4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule